// File: doc/BRIEF.md
# Channel-Scaled Audio Sample FIFO

This block holds audio samples between a processor-side register port and an audio serializer. Storage is a fixed pool of sample slots, 256 by default. How many frames fit in that pool depends on the configured channel count, which is rounded up to the next power of two. Software pushes 24-bit samples through a data register. The serializer pops one sample per read strobe.

A status register reports the fill level in whole frames, along with two sticky error flags. One flag records a push that was refused because the FIFO was full. The other records a pop from an empty FIFO. A control register carries a self-clearing flush bit and an enable for a level interrupt. The interrupt asks software for more data while the FIFO holds half of its frame capacity or less.

Top module: `chscale_sample_fifo`

## Requirements
- R1: A sample write stores only the low 24 bits of the data word. The serializer receives samples in the order they were written, on `ser_data` one cycle after the `ser_rd` strobe.
- R2: `cfg_chan_m1` holds the channel count minus one. Frame capacity is 256 for 1 channel, 128 for 2, 64 for 3 or 4, and 32 for 5 to 8. Sample capacity is the frame capacity times the channel count.
- R3: A sample write while the FIFO holds its full sample capacity is dropped. The stored contents and the fill level stay unchanged.
- R4: A dropped write sets the overrun flag, which is status bit 4.
- R5: A pop from an empty FIFO returns zero on `ser_data`, sets the underrun flag (status bit 0) and leaves the fill level at zero.
- R6: Both error flags are sticky. A write to the status register clears each flag whose bit is written as 0, so writing zero clears both. A new error in the same cycle wins over the clear.
- R7: Writing 1 to control bit 0 sets that bit for exactly one cycle. On the following edge the pointers and the fill level reset to empty.
- R8: Status bits [16:8] hold the number of whole frames stored: the stored sample count divided by the channel count, rounded down.
- R9: With control bit 20 set, `irq` is high while the frame fill level is at most half the frame capacity, one cycle after that condition. `irq` is low otherwise, and low one cycle after bit 20 is cleared.
- R10: Register select 0 is control, 1 is status and 2 is the sample data port. Reading the data port or select 3 returns zero, and after reset both control and status read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chan_m1 | input | 3 | Channel count minus one |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select (0 control, 1 status, 2 data) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for the selected register |
| ser_rd | input | 1 | Serializer pop strobe |
| ser_data | output | 24 | Popped sample, valid the cycle after the strobe |
| irq | output | 1 | Half-level interrupt request |

## Verification
The bench builds the block with its default parameters: 256 slots, 24-bit samples and up to eight channels. With these values every capacity group can be filled past full within a few hundred writes. The channel counts 1, 2, 3, 4, 5 and 8 cover each rounding group, including non-power-of-two counts where the sample capacity is not a power of two. These same values also bring the floor rounding of a partial frame within reach, and the exact crossing point of the half-level interrupt.

// File: rtl/chsf_pkg.sv
package chsf_pkg;

  localparam int CTRL_FLUSH_BIT = 0;
  localparam int CTRL_IE_BIT    = 20;
  localparam int STAT_UND_BIT   = 0;
  localparam int STAT_OVR_BIT   = 4;
  localparam int STAT_FILL_LSB  = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // smallest power of two not below the channel count
  function automatic int unsigned lane_group(input int unsigned chans);
    int unsigned g;
    g = 1;
    for (int i = 0; i < 16; i++) begin
      if (g < chans) g = g << 1;
    end
    return g;
  endfunction

  function automatic int unsigned frame_cap(input int unsigned slots, input int unsigned chans);
    return slots / lane_group(chans);
  endfunction

  function automatic int unsigned sample_cap(input int unsigned slots, input int unsigned chans);
    return frame_cap(slots, chans) * chans;
  endfunction

  function automatic int unsigned samples_to_frames(input int unsigned cnt, input int unsigned chans);
    return (chans == 0) ? cnt : cnt / chans;
  endfunction

endpackage

// File: rtl/chsf_store.sv
module chsf_store #(
  parameter int SLOTS = 256,
  parameter int DW    = 24,
  localparam int AW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_zero,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_zero ? '0 : mem[rd_idx];
    end
  end

endmodule

// File: rtl/chsf_level.sv
module chsf_level
  import chsf_pkg::*;
#(
  parameter int SLOTS = 256,
  parameter int CHNW  = 4,
  localparam int AW   = $clog2(SLOTS),
  localparam int CW   = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CHNW-1:0] chans,
  input  logic            push_req,
  input  logic            pop_req,
  input  logic            flush,
  output logic [AW-1:0]   wr_idx,
  output logic [AW-1:0]   rd_idx,
  output logic [CW-1:0]   sample_cnt,
  output logic [CW-1:0]   cap_samples,
  output logic [CW-1:0]   cap_frames,
  output logic [CW-1:0]   fill_frames,
  output logic            push_ok,
  output logic            push_drop,
  output logic            pop_ok,
  output logic            pop_empty
);

  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    cap_samples = CW'(sample_cap(SLOTS, int'(chans)));
    cap_frames  = CW'(frame_cap(SLOTS, int'(chans)));
    fill_frames = CW'(samples_to_frames(int'(cnt_q), int'(chans)));
    push_ok     = push_req && (cnt_q < cap_samples);
    push_drop   = push_req && !(cnt_q < cap_samples);
    pop_ok      = pop_req && (cnt_q != '0);
    pop_empty   = pop_req && (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + AW'(1);
      if (pop_ok)  rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assign wr_idx     = wr_q;
  assign rd_idx     = rd_q;
  assign sample_cnt = cnt_q;

endmodule

// File: rtl/chsf_regs.sv
module chsf_regs
  import chsf_pkg::*;
#(
  parameter int BW = 32,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_sel,
  input  logic [BW-1:0] bus_wdata,
  input  logic          push_drop,
  input  logic          pop_empty,
  input  logic [CW-1:0] fill_frames,
  input  logic [CW-1:0] cap_frames,
  output logic          push_req,
  output logic          flush_q,
  output logic          ie_q,
  output logic          ovr_q,
  output logic          und_q,
  output logic          irq_q,
  output logic [BW-1:0] bus_rdata
);

  logic ctrl_wr, stat_wr, below_half;
  logic unused_wdata;

  assign ctrl_wr      = bus_wr && (reg_sel_e'(bus_sel) == SEL_CTRL);
  assign stat_wr      = bus_wr && (reg_sel_e'(bus_sel) == SEL_STAT);
  assign push_req     = bus_wr && (reg_sel_e'(bus_sel) == SEL_DATA);
  assign below_half   = fill_frames <= (cap_frames >> 1);
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      ie_q    <= 1'b0;
      ovr_q   <= 1'b0;
      und_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      flush_q <= ctrl_wr && bus_wdata[CTRL_FLUSH_BIT];
      if (ctrl_wr) ie_q <= bus_wdata[CTRL_IE_BIT];
      ovr_q <= push_drop || (ovr_q && !(stat_wr && !bus_wdata[STAT_OVR_BIT]));
      und_q <= pop_empty || (und_q && !(stat_wr && !bus_wdata[STAT_UND_BIT]));
      irq_q <= ie_q && below_half;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (reg_sel_e'(bus_sel))
      SEL_CTRL: begin
        bus_rdata[CTRL_FLUSH_BIT] = flush_q;
        bus_rdata[CTRL_IE_BIT]    = ie_q;
      end
      SEL_STAT: begin
        bus_rdata[STAT_FILL_LSB +: CW] = fill_frames;
        bus_rdata[STAT_OVR_BIT]        = ovr_q;
        bus_rdata[STAT_UND_BIT]        = und_q;
      end
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/chscale_sample_fifo.sv
module chscale_sample_fifo #(
  parameter int SLOTS = 256,
  parameter int DW    = 24,
  parameter int MAXCH = 8,
  parameter int BW    = 32,
  localparam int AW   = $clog2(SLOTS),
  localparam int CW   = AW + 1,
  localparam int CHW  = $clog2(MAXCH),
  localparam int CHNW = CHW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CHW-1:0] cfg_chan_m1,
  input  logic           bus_wr,
  input  logic [1:0]     bus_sel,
  input  logic [BW-1:0]  bus_wdata,
  output logic [BW-1:0]  bus_rdata,
  input  logic           ser_rd,
  output logic [DW-1:0]  ser_data,
  output logic           irq
);

  logic [CHNW-1:0] chans;
  logic [AW-1:0]   wr_idx, rd_idx;
  logic [CW-1:0]   sample_cnt, cap_samples, cap_frames, fill_frames;
  logic            push_req, push_ok, push_drop, pop_ok, pop_empty;
  logic            flush_q, ie_q, ovr_q, und_q;

  assign chans = CHNW'(cfg_chan_m1) + CHNW'(1);

  chsf_level #(.SLOTS(SLOTS), .CHNW(CHNW)) u_level (
    .clk(clk), .rst_n(rst_n), .chans(chans),
    .push_req(push_req), .pop_req(ser_rd), .flush(flush_q),
    .wr_idx(wr_idx), .rd_idx(rd_idx),
    .sample_cnt(sample_cnt), .cap_samples(cap_samples),
    .cap_frames(cap_frames), .fill_frames(fill_frames),
    .push_ok(push_ok), .push_drop(push_drop),
    .pop_ok(pop_ok), .pop_empty(pop_empty)
  );

  chsf_store #(.SLOTS(SLOTS), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_ok), .wr_idx(wr_idx), .wr_data(bus_wdata[DW-1:0]),
    .rd_en(ser_rd), .rd_zero(pop_empty), .rd_idx(rd_idx),
    .rd_data(ser_data)
  );

  chsf_regs #(.BW(BW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .push_drop(push_drop), .pop_empty(pop_empty),
    .fill_frames(fill_frames), .cap_frames(cap_frames),
    .push_req(push_req), .flush_q(flush_q), .ie_q(ie_q),
    .ovr_q(ovr_q), .und_q(und_q), .irq_q(irq), .bus_rdata(bus_rdata)
  );

endmodule

// File: rtl/chsf_checker.sv
module chsf_checker #(
  parameter int DW = 24,
  parameter int BW = 32,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [1:0]    bus_sel,
  input logic [BW-1:0] bus_wdata,
  input logic [DW-1:0] ser_data,
  input logic          irq,
  input logic [CW-1:0] sample_cnt,
  input logic [CW-1:0] cap_samples,
  input logic [CW-1:0] cap_frames,
  input logic [CW-1:0] fill_frames,
  input logic          push_drop,
  input logic          pop_ok,
  input logic          pop_empty,
  input logic          flush_q,
  input logic          ie_q,
  input logic          ovr_q,
  input logic          und_q
);

  logic flush_wr, ovr_clr_wr;
  assign flush_wr   = bus_wr && (bus_sel == 2'd0) && bus_wdata[0];
  assign ovr_clr_wr = bus_wr && (bus_sel == 2'd1) && !bus_wdata[4];

  a_r2_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
    sample_cnt <= cap_samples);

  a_r3_drop_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_ok && !flush_q) |=> (sample_cnt == $past(sample_cnt)));

  a_r4_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovr_q);

  a_r5_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |=> (ser_data == '0 && und_q));

  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr_wr) |=> ovr_q);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> (sample_cnt == '0));

  a_r7_flush_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && !flush_wr) |=> !flush_q);

  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(ie_q && (fill_frames <= (cap_frames >> 1))));

endmodule

bind chscale_sample_fifo chsf_checker #(.DW(DW), .BW(BW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .ser_data(ser_data), .irq(irq),
  .sample_cnt(sample_cnt), .cap_samples(cap_samples),
  .cap_frames(cap_frames), .fill_frames(fill_frames),
  .push_drop(push_drop), .pop_ok(pop_ok), .pop_empty(pop_empty),
  .flush_q(flush_q), .ie_q(ie_q), .ovr_q(ovr_q), .und_q(und_q)
);

// File: tb/test_chscale_sample_fifo.sv
module test_chscale_sample_fifo;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_chan_m1 = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_rd = 1'b0;
  logic [23:0] ser_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chscale_sample_fifo i_chscale_sample_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_chan_m1(cfg_chan_m1),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ser_rd(ser_rd), .ser_data(ser_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] st(input int fill, input bit ovr, input bit und);
    return (32'(fill) << 8) | (32'(ovr) << 4) | 32'(und);
  endfunction

  function automatic int exp_frames(input int m1);
    case (m1)
      0: return 256;
      1: return 128;
      2, 3: return 64;
      default: return 32;
    endcase
  endfunction

  task automatic cpu_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic cpu_read(input logic [1:0] sel, output logic [31:0] data);
    bus_sel = sel;
    #1;
    data = bus_rdata;
  endtask

  task automatic ser_pop(output logic [23:0] data);
    @(negedge clk);
    ser_rd = 1'b1;
    @(negedge clk);
    ser_rd = 1'b0;
    data = ser_data;
  endtask

  task automatic restart(input int m1);
    @(negedge clk);
    cfg_chan_m1 = 3'(m1);
    cpu_write(2'd0, 32'h1);
    @(negedge clk);
    cpu_write(2'd1, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    cpu_read(2'd0, v); chk("R10 ctrl after reset", v, 32'h0);
    cpu_read(2'd1, v); chk("R10 status after reset", v, 32'h0);
    chk("R9 irq after reset", 32'(irq), 32'h0);
  endtask

  task automatic t_order_mask;
    logic [23:0] d;
    logic [31:0] v;
    restart(0);
    cpu_write(2'd2, 32'hAB12_3456);
    cpu_write(2'd2, 32'h00FF_FFFF);
    cpu_write(2'd2, 32'h0100_0001);
    cpu_read(2'd2, v); chk("R10 data port reads zero", v, 32'h0);
    cpu_read(2'd3, v); chk("R10 unused select reads zero", v, 32'h0);
    ser_pop(d); chk("R1 first sample masked", 32'(d), 32'h12_3456);
    ser_pop(d); chk("R1 second sample", 32'(d), 32'hFF_FFFF);
    ser_pop(d); chk("R1 third sample masked", 32'(d), 32'h00_0001);
  endtask

  task automatic t_capacity(input int m1);
    int chans, frames, samples, bad;
    logic [31:0] v;
    logic [23:0] d;
    chans = m1 + 1;
    frames = exp_frames(m1);
    samples = frames * chans;
    restart(m1);
    for (int k = 0; k < samples + 2; k++) cpu_write(2'd2, 32'(k + 1) | (32'(m1) << 20));
    cpu_read(2'd1, v);
    chk($sformatf("R2 R4 R8 full fill and overrun, chans=%0d", chans), v, st(frames, 1, 0));
    bad = 0;
    for (int k = 0; k < samples; k++) begin
      ser_pop(d);
      if (d !== 24'((k + 1) | (m1 << 20))) bad++;
    end
    chk($sformatf("R1 R3 stored data after overfill, chans=%0d", chans), 32'(bad), 32'h0);
    cpu_read(2'd1, v);
    chk($sformatf("R3 drained with no underrun, chans=%0d", chans), v, st(0, 1, 0));
    ser_pop(d);
    cpu_read(2'd1, v);
    chk($sformatf("R3 no dropped word stored, chans=%0d", chans), v, st(0, 1, 1));
  endtask

  task automatic t_partial;
    logic [31:0] v;
    restart(2);
    for (int k = 0; k < 7; k++) cpu_write(2'd2, 32'(k));
    cpu_read(2'd1, v); chk("R8 seven samples of three channels", v, st(2, 0, 0));
    restart(4);
    for (int k = 0; k < 4; k++) cpu_write(2'd2, 32'(k));
    cpu_read(2'd1, v); chk("R8 partial frame counts zero", v, st(0, 0, 0));
  endtask

  task automatic t_underrun;
    logic [23:0] d;
    logic [31:0] v;
    restart(0);
    cpu_write(2'd2, 32'h55AA55);
    ser_pop(d); chk("R1 sample before underrun", 32'(d), 32'h55AA55);
    ser_pop(d); chk("R5 empty pop returns zero", 32'(d), 32'h0);
    cpu_read(2'd1, v); chk("R5 underrun flag, fill zero", v, st(0, 0, 1));
  endtask

  task automatic t_sticky;
    logic [23:0] d;
    logic [31:0] v;
    restart(0);
    ser_pop(d);
    for (int k = 0; k < 257; k++) cpu_write(2'd2, 32'(k));
    repeat (3) @(negedge clk);
    cpu_read(2'd1, v); chk("R6 both flags held", v, st(256, 1, 1));
    cpu_write(2'd1, 32'h10);
    cpu_read(2'd1, v); chk("R6 selective clear of underrun", v, st(256, 1, 0));
    cpu_write(2'd1, 32'h0);
    cpu_read(2'd1, v); chk("R6 zero write clears both", v, st(256, 0, 0));
  endtask

  task automatic t_flush;
    logic [31:0] v;
    logic [23:0] d;
    restart(0);
    for (int k = 0; k < 5; k++) cpu_write(2'd2, 32'(k + 9));
    cpu_write(2'd0, 32'h1);
    cpu_read(2'd0, v); chk("R7 flush bit visible one cycle", v, 32'h1);
    @(negedge clk);
    cpu_read(2'd0, v); chk("R7 flush bit self-cleared", v, 32'h0);
    cpu_read(2'd1, v); chk("R7 fill zero after flush", v, st(0, 0, 0));
    ser_pop(d); chk("R7 pop after flush returns zero", 32'(d), 32'h0);
  endtask

  task automatic t_irq;
    logic [23:0] d;
    restart(0);
    cpu_write(2'd0, 32'h0010_0000);
    @(negedge clk);
    chk("R9 irq when empty and enabled", 32'(irq), 32'h1);
    for (int k = 0; k < 128; k++) cpu_write(2'd2, 32'(k));
    @(negedge clk);
    chk("R9 irq at exactly half", 32'(irq), 32'h1);
    cpu_write(2'd2, 32'h7);
    @(negedge clk);
    chk("R9 irq low above half", 32'(irq), 32'h0);
    ser_pop(d);
    @(negedge clk);
    chk("R9 irq back at half", 32'(irq), 32'h1);
    cpu_write(2'd0, 32'h0);
    @(negedge clk);
    chk("R9 irq masked", 32'(irq), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_mask();
    t_capacity(0);
    t_capacity(1);
    t_capacity(2);
    t_capacity(3);
    t_capacity(4);
    t_capacity(7);
    t_partial();
    t_underrun();
    t_sticky();
    t_flush();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule